// File: doc/BRIEF.md
# Dual-Buffer Scanout Address Sequencer

This block walks a display DMA engine through frame buffers in memory. Software programs two address windows, each with an inclusive first and last word address. While running, the sequencer fetches one window per frame. It can ping-pong between the two windows or stay on the first one. Each frame is fetched as a series of bursts over a request/acknowledge read port. The returned words are pushed into an internal pixel FIFO, which the downstream raster logic drains through a valid/ready pair.

A new burst is issued only when two conditions hold: the FIFO fill level is at or below a programmable threshold, and the FIFO has room for the whole burst. Window writes go into shadow registers, and a window is loaded only when that buffer's frame begins. As a result, reprogramming a window during a frame never splits that frame across two windows. Clearing the run bit does not cut the current frame short: the frame completes, then a frame-done flag is raised. Sticky status bits can be routed to an interrupt line. Software can recover from a combined underflow and sync-loss event by stopping, clearing the status and restarting.

Top module: `scanout_seq`

## Requirements
- R1: After reset, mem_req, status, irq and fifo_level are 0 and pix_valid is low.
- R2: Window registers sit at write addresses 1 (buffer 0 first word), 2 (buffer 0 last word), 3 (buffer 1 first word) and 4 (buffer 1 last word). A frame reads every word from first to last inclusive, stepping by one word. Each burst has length min(burst size, words left), so no burst reaches past the last word.
- R3: The control register is at write address 0. Its bits [6:4] select the burst size: 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 words. A control write carrying a value of 5, 6 or 7 in that field leaves the previous burst size in force.
- R4: Control bits [12:8] hold a threshold. A burst is requested only when fifo_level is less than or equal to the threshold and fifo_level plus the burst length does not exceed the FIFO depth.
- R5: Control bit 0 is run. When control bit 1 is 1, consecutive frames alternate between buffer 0 and buffer 1. When it is 0, every frame uses buffer 0.
- R6: When the last word of a frame is returned, status bit 0 is set if the frame came from buffer 0, and status bit 1 is set if it came from buffer 1.
- R7: A window write takes effect at the next start of a frame from that buffer. The frame in progress keeps its old window.
- R8: When run is cleared, the frame in progress is fetched to its last word. Status bit 2 (frame done) is then set and no further request is made.
- R9: Status bit 3 (underflow) is set when pix_ready is high while the FIFO is empty and run is set. Status bit 4 (sync lost) is set by a high sync_err input.
- R10: Writing to address 5 clears each status bit written as 1 and leaves the others. Address 6 holds an enable mask, and irq is the OR of status ANDed with that mask.
- R11: Setting run from the stopped state starts fetching at buffer 0's first word, whichever buffer was used last.
- R12: mem_req, mem_addr and mem_len stay constant until mem_ack. Pixels leave the FIFO in the order the words were returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | AW | Register write data |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | AW | First word address of the burst |
| mem_len | output | 5 | Burst length in words |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | DW | Read word |
| pix_valid | output | 1 | FIFO not empty |
| pix_data | output | DW | FIFO head word |
| pix_ready | input | 1 | Downstream takes a word |
| fifo_level | output | LW | Words held in the FIFO |
| sync_err | input | 1 | Sync-loss event from raster timing |
| status | output | 5 | Sticky status flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the memory side behaves:
- mem_ack comes only while mem_req is high.
- Exactly mem_len words return, after the acknowledge and before the next request.
- Every window has its first word at or below its last, and spans fewer than 2^AW words.

The bench's memory responder acknowledges only a visible request and then returns exactly the requested count of words. All programmed windows satisfy first ≤ last. The downstream reader pops only valid words, except in the one phase that provokes underflow on purpose.

// File: rtl/scanout_seq.sv
module scanout_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int FD = 16,
  parameter int TW = 5,
  parameter int LW = $clog2(FD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [4:0]    mem_len,
  input  logic          mem_ack,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          pix_valid,
  output logic [DW-1:0] pix_data,
  input  logic          pix_ready,
  output logic [LW-1:0] fifo_level,
  input  logic          sync_err,
  output logic [4:0]    status,
  output logic          irq
);
  localparam int PW = $clog2(FD);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REQ, S_DATA} st_t;
  st_t state;

  logic          run, dual;
  logic [2:0]    bcode;
  logic [TW-1:0] thr;
  logic [4:0]    ien, st;
  logic [AW-1:0] wbase [2];
  logic [AW-1:0] wceil [2];
  logic          cur_buf;
  logic [AW-1:0] addr, ceil_a, len_r;
  logic [4:0]    rem;
  logic [DW-1:0] fifo_mem [FD];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cnt;

  wire [AW-1:0] blen  = AW'(1) << bcode;
  wire [AW-1:0] span  = ceil_a - addr + AW'(1);
  wire [AW-1:0] len_n = (span < blen) ? span : blen;
  wire push      = (state == S_DATA) && mem_rvalid;
  wire pop       = pix_ready && (cnt != '0);
  wire last_w    = push && (rem == 5'd1);
  wire frame_end = last_w && (len_r == span);
  wire room      = (AW'(cnt) + len_n) <= AW'(FD);
  wire below     = AW'(cnt) <= AW'(thr);
  wire nb        = dual ? ~cur_buf : 1'b0;
  wire [4:0] clr  = (reg_we && reg_addr == 3'd5) ? reg_wdata[4:0] : 5'd0;
  wire [4:0] setv = {sync_err, pix_ready && (cnt == '0) && run, frame_end && !run,
                     frame_end && cur_buf, frame_end && !cur_buf};

  assign mem_req    = (state == S_REQ);
  assign mem_addr   = addr;
  assign mem_len    = len_r[4:0];
  assign pix_valid  = (cnt != '0);
  assign pix_data   = fifo_mem[rp];
  assign fifo_level = cnt;
  assign status     = st;
  assign irq        = |(st & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; dual <= 1'b0; bcode <= '0; thr <= TW'(FD);
      ien <= '0; st <= '0;
      wbase[0] <= '0; wbase[1] <= '0; wceil[0] <= '0; wceil[1] <= '0;
    end else begin
      st <= (st & ~clr) | setv;
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin
            run  <= reg_wdata[0];
            dual <= reg_wdata[1];
            if (reg_wdata[6:4] <= 3'd4) bcode <= reg_wdata[6:4];
            thr  <= reg_wdata[8 +: TW];
          end
          3'd1: wbase[0] <= reg_wdata;
          3'd2: wceil[0] <= reg_wdata;
          3'd3: wbase[1] <= reg_wdata;
          3'd4: wceil[1] <= reg_wdata;
          3'd6: ien <= reg_wdata[4:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cur_buf <= 1'b0; addr <= '0; ceil_a <= '0;
      len_r <= '0; rem <= '0; wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + LW'(push) - LW'(pop);
      case (state)
        S_IDLE: if (run) begin
          state <= S_WAIT; cur_buf <= 1'b0;
          addr <= wbase[0]; ceil_a <= wceil[0];
          wp <= '0; rp <= '0; cnt <= '0;
        end
        S_WAIT: if (below && room) begin
          len_r <= len_n; state <= S_REQ;
        end
        S_REQ: if (mem_ack) begin
          rem <= len_r[4:0]; state <= S_DATA;
        end
        S_DATA: if (last_w) begin
          if (frame_end) begin
            if (!run) state <= S_IDLE;
            else begin
              state <= S_WAIT; cur_buf <= nb;
              addr <= wbase[nb]; ceil_a <= wceil[nb];
            end
          end else begin
            addr <= addr + len_r; state <= S_WAIT;
          end
        end else if (push) rem <= rem - 5'd1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) if (push) fifo_mem[wp] <= mem_rdata;

  // R2
  ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((AW+1)'(mem_addr) + (AW+1)'(mem_len) <= (AW+1)'(ceil_a) + (AW+1)'(1)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

  // R4
  lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(FD));

  // R8
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> !$past(run));
endmodule

// File: tb/scanout_seq_tb.sv
module scanout_seq_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [15:0] reg_wdata = 0;
  logic mem_req, mem_ack = 0, mem_rvalid = 0;
  logic [15:0] mem_addr, mem_rdata = 0;
  logic [4:0] mem_len, status;
  logic pix_valid, pix_ready, irq, sync_err = 0;
  logic [15:0] pix_data;
  logic [4:0] fifo_level;
  logic cons_en = 0, force_rd = 0;

  assign pix_ready = force_rd | (cons_en & pix_valid);
  always #(CLK_NS/2) clk = ~clk;

  scanout_seq u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .fifo_level(fifo_level), .sync_err(sync_err), .status(status), .irq(irq));

  int n_chk = 0, n_fail = 0;
  int bp_base [2], bp_ceil [2];
  int blen_m = 1; bit dual_m = 0; logic [15:0] ctrl_m = 0;
  int tb_buf, tb_addr, tb_ceil, hits400 = 0;
  bit tb_fresh = 1;
  int frames [2];
  string tag_m = "R2/R5 burst";
  int q [$];
  int r_a = 0, r_cnt = 0, r_len = 0; bit ack_d = 0;
  int lens [4] = '{1, 7, 16, 23};

  function automatic int pf(int a); return (a ^ 'h5A3C) & 'hFFFF; endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // memory responder and burst tracker
  always @(negedge clk) begin
    if (ack_d) begin
      ack_d = 0; mem_ack = 0; mem_rvalid = 1; mem_rdata = 16'(pf(r_a));
      q.push_back(r_a); r_a++; r_cnt = r_len - 1;
    end else if (r_cnt != 0) begin
      mem_rdata = 16'(pf(r_a)); q.push_back(r_a); r_a++; r_cnt--;
    end else begin
      mem_rvalid = 0;
      if (mem_req) begin
        int exp_len;
        mem_ack = 1; ack_d = 1; r_a = mem_addr; r_len = mem_len;
        exp_len = tb_ceil - tb_addr + 1;
        if (exp_len > blen_m) exp_len = blen_m;
        chk({tag_m, " address"}, mem_addr, tb_addr);
        chk({tag_m, " length"}, mem_len, exp_len);
        if (mem_addr == 16'h0400) hits400++;
        tb_addr += exp_len; tb_fresh = 0;
        if (tb_addr > tb_ceil) begin
          frames[tb_buf]++;
          tb_buf = dual_m ? 1 - tb_buf : 0;
          tb_addr = bp_base[tb_buf]; tb_ceil = bp_ceil[tb_buf]; tb_fresh = 1;
        end
      end
    end
  end

  // pixel order checker
  always @(negedge clk) begin
    #1;
    if (pix_valid && pix_ready) begin
      if (q.size() == 0) chk("R12 pixel with none pending", 1, 0);
      else chk("R12 pixel order", pix_data, pf(q.pop_front()));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic set_win(int b, int base, int ceil);
    bp_base[b] = base; bp_ceil[b] = ceil;
    wr(3'(1 + 2*b), 16'(base)); wr(3'(2 + 2*b), 16'(ceil));
  endtask

  task automatic start_run(logic [15:0] ctrl);
    q.delete();
    tb_buf = 0; tb_addr = bp_base[0]; tb_ceil = bp_ceil[0]; tb_fresh = 1;
    frames[0] = 0; frames[1] = 0;
    wr(3'd5, 16'h001f);
    ctrl_m = ctrl | 16'h1;
    wr(3'd0, ctrl_m);
  endtask

  task automatic wait_frames(int n);
    for (int k = 0; k < 20000 && frames[0] + frames[1] < n; k++) @(negedge clk);
  endtask

  task automatic stop_and_drain();
    ctrl_m = ctrl_m & ~16'h1;
    wr(3'd0, ctrl_m);
    force_rd = 0; cons_en = 1;
    for (int k = 0; k < 8000 && !status[2]; k++) @(negedge clk);
    chk("R8 frame done flag", status[2], 1);
    chk("R8 stop lands on frame boundary", tb_fresh, 1);
    for (int k = 0; k < 300 && (fifo_level != 0 || q.size() != 0); k++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R8 no request after done", mem_req, 0);
    chk("R12 all returned words delivered", q.size(), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R12: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bp_base[0] = 0; bp_ceil[0] = 0; bp_base[1] = 0; bp_ceil[1] = 0;
    frames[0] = 0; frames[1] = 0; tb_buf = 0; tb_addr = 0; tb_ceil = 0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 mem_req", mem_req, 0); chk("R1 status", status, 0);
    chk("R1 irq", irq, 0); chk("R1 fifo_level", fifo_level, 0);
    chk("R1 pix_valid", pix_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", mem_req, 0);

    // sweep: burst sizes x window lengths x single/dual (R2, R3, R5, R6)
    for (int c = 0; c < 5; c++)
      for (int li = 0; li < 4; li++)
        for (int d = 0; d < 2; d++) begin
          set_win(0, 'h0100, 'h0100 + lens[li] - 1);
          set_win(1, 'h2000, 'h2000 + lens[li] + 2);
          blen_m = 1 << c; dual_m = d[0];
          tag_m = "R2/R3/R5 burst";
          cons_en = 1;
          start_run(16'((16 << 8) | (c << 4) | (d << 1)));
          wait_frames(3);
          stop_and_drain();
          chk("R6 buffer 0 end-of-frame", status[0], 1);
          chk("R6 buffer 1 end-of-frame", status[1], (d == 1 && frames[1] > 0) ? 1 : 0);
          chk("R10 irq masked off", irq, 0);
        end

    // R4 threshold sweep with reader stalled
    set_win(0, 'h0300, 'h033F);
    blen_m = 4; dual_m = 0; tag_m = "R4 burst";
    for (int t = 0; t <= 16; t++) begin
      int exp_lvl;
      exp_lvl = (t / 4 + 1) * 4;
      if (exp_lvl > 16) exp_lvl = 16;
      cons_en = 0; force_rd = 0;
      start_run(16'((t << 8) | (2 << 4)));
      repeat (100) @(negedge clk);
      chk("R4 fill level at threshold", fifo_level, exp_lvl);
      stop_and_drain();
    end

    // R3 illegal burst code keeps previous size (4 words)
    set_win(0, 'h0500, 'h0509);
    blen_m = 4; tag_m = "R3 illegal code burst";
    cons_en = 1;
    start_run(16'((16 << 8) | (6 << 4)));
    wait_frames(2);
    stop_and_drain();

    // R7 shadowed window update
    set_win(0, 'h0100, 'h0117);
    blen_m = 4; tag_m = "R7 shadow burst"; hits400 = 0;
    start_run(16'((16 << 8) | (2 << 4)));
    for (int k = 0; k < 2000 && !(tb_addr == 'h0108 && frames[0] == 0); k++) @(negedge clk);
    set_win(0, 'h0400, 'h040B);
    wait_frames(3);
    stop_and_drain();
    chk("R7 new window used in later frame", hits400 > 0, 1);

    // R9 / R10 status and interrupt
    set_win(0, 'h0600, 'h0627);
    set_win(1, 'h0700, 'h0713);
    blen_m = 4; dual_m = 1; tag_m = "R9 burst";
    wr(3'd6, 16'h0018);
    cons_en = 0; force_rd = 1;
    start_run(16'((16 << 8) | (2 << 4) | 2));
    repeat (5) @(negedge clk);
    chk("R9 underflow flag", status[3], 1);
    chk("R10 irq from underflow", irq, 1);
    @(negedge clk); sync_err = 1;
    @(negedge clk); sync_err = 0;
    chk("R9 sync lost flag", status[4], 1);
    force_rd = 0; cons_en = 1;
    wr(3'd5, 16'h0008);
    chk("R10 cleared bit", status[3], 0);
    chk("R10 other bit kept", status[4], 1);
    chk("R10 irq from sync lost", irq, 1);
    wr(3'd6, 16'h0008);
    chk("R10 irq masked", irq, 0);
    wait_frames(3);
    stop_and_drain();
    wr(3'd5, 16'h001f);
    chk("R10 all status cleared", status, 0);

    // R11 restart begins at buffer 0
    tag_m = "R11 restart burst";
    start_run(16'((16 << 8) | (2 << 4) | 2));
    wait_frames(2);
    stop_and_drain();
    chk("R11 buffer 0 frame seen after restart", frames[0] > 0, 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule